// File: doc/BRIEF.md
# Thread-Masked Memory Request Batcher

This block sits between an instruction issue stage and a lane-wide memory port. It takes one memory instruction at a time. Each instruction carries one address per thread, a mask of active threads and an operation class: load, store, atomic or fence. The block gathers the addresses of the active threads in ascending thread order. It sends them to memory as a run of requests, and each request holds at most the lane count of addresses. Every request also carries a lane-fill mask, a write flag and an end-of-packet flag.

Read batches reserve an entry in a small pending-read table and carry that entry's index as their tag. The memory side frees the entry by returning the tag on the response port. Write batches reserve nothing. A store reports completion as soon as its last batch has left, and an instruction with no active threads completes without touching memory. A fence blocks new instructions until every outstanding read has returned, and then reports completion.

Top module: `mem_batcher`

## Requirements
- R1: After reset, `inReady` is 1, `reqValid` is 0 and `doneValid` is 0, and every pending-read slot is free.
- R2: Only threads whose `inMask` bit is set contribute addresses, taken in ascending thread order. A request fills lanes from lane 0 upward (lane k in bits k*ADDR_W up to k*ADDR_W+ADDR_W-1 of `reqAddrs`), and `reqLaneMask` bit k is 1 exactly when lane k holds an address.
- R3: Each request carries at most NUM_LANES addresses. Every request except the last of an instruction is full. With `reqReady` held at 1, the batches of one instruction go out in consecutive cycles.
- R4: `reqEop` is 1 on the final batch of an instruction and 0 on every earlier batch. After the final handshake, `reqValid` is 0.
- R5: A read batch reserves the lowest-numbered free pending-read slot and carries its index on `reqTag`. A write batch carries tag 0 and reserves nothing. A `rspValid` pulse frees slot `rspTag`.
- R6: While every pending-read slot is held, a read batch is not offered (`reqValid` 0). It keeps its place in the instruction and is offered in the cycle after a response frees a slot.
- R7: Operation codes on `inOp` are 0 load, 1 store, 2 atomic and 3 fence. Loads are reads (`reqWrite` 0) and stores are writes. An atomic is a write unless `inReserve` is 1 (load-reserved), in which case it is a read.
- R8: A write instruction pulses `doneValid` for one cycle, in the cycle after its final batch handshake. A read instruction does not raise `doneValid`.
- R9: A non-fence instruction with an all-zero mask raises `doneValid` in the cycle after acceptance and issues no request.
- R10: A fence is accepted at once and then holds `inReady` at 0. In the cycle after the pending-read table is seen empty, `doneValid` pulses and `inReady` returns to 1.
- R11: While `reqValid` is 1 and `reqReady` is 0, `reqAddrs`, `reqLaneMask`, `reqEop` and `reqWrite` hold their values. The batch position advances only on a completed handshake.
- R12: `inReady` is 0 while any batch of the current instruction is still to be sent, and the instruction inputs are sampled only at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Block can accept an instruction |
| inOp | input | 2 | Operation class: 0 load, 1 store, 2 atomic, 3 fence |
| inReserve | input | 1 | Atomic is load-reserved (treated as a read) |
| inMask | input | NUM_THREADS | Active-thread mask |
| inAddrs | input | NUM_THREADS*ADDR_W | Per-thread addresses, thread t in slice t |
| reqValid | output | 1 | Memory request offered |
| reqReady | input | 1 | Memory side takes the request |
| reqWrite | output | 1 | Request is a write |
| reqTag | output | TAG_W | Pending-read slot of a read, 0 for a write |
| reqEop | output | 1 | Final batch of the instruction |
| reqLaneMask | output | NUM_LANES | Filled lanes of the request |
| reqAddrs | output | NUM_LANES*ADDR_W | Lane addresses, lane k in slice k |
| rspValid | input | 1 | A read has fully returned |
| rspTag | input | TAG_W | Slot freed by the response |
| doneValid | output | 1 | One-cycle completion pulse (write, empty or fence) |

## Verification
The assertions assume that the memory side returns only tags whose slot is currently held, and each such tag once. They also assume that `inOp` uses the four listed codes. The bench keeps its own model of slot occupancy and releases only tags that this model marks as held, one per cycle. It drives `inOp` only with the listed codes. Backpressure and slot exhaustion are produced on purpose, and the bench never frees a slot that the design has not handed out.

// File: rtl/mb_pkg.sv
package mb_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_ATOMIC = 2'd2,
    OP_FENCE  = 2'd3
  } memOpE;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FENCE = 2'd2
  } batchStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch a new instruction
    logic advance;  // retire the lanes of the current batch
  } dpCtrlT;

endpackage

// File: rtl/mb_slot_table.sv
module mb_slot_table #(
  parameter int SLOTS = 4,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allocate,
  input  logic             releaseValid,
  input  logic [TAG_W-1:0] releaseTag,
  output logic [TAG_W-1:0] allocTag,
  output logic             full,
  output logic             empty,
  output logic [SLOTS-1:0] occupied
);

  logic [SLOTS-1:0] occQ;
  logic [SLOTS-1:0] setVec;
  logic [SLOTS-1:0] clrVec;

  // lowest free slot wins
  always_comb begin
    allocTag = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!occQ[s]) allocTag = TAG_W'(s);
    end
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      setVec[s] = allocate && (allocTag == TAG_W'(s));
      clrVec[s] = releaseValid && (releaseTag == TAG_W'(s));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occQ <= '0;
    else        occQ <= (occQ | setVec) & ~clrVec;
  end

  assign full     = &occQ;
  assign empty    = ~|occQ;
  assign occupied = occQ;

endmodule

// File: rtl/mb_datapath.sv
module mb_datapath import mb_pkg::*; #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_LANES   = 4,
  parameter int ADDR_W      = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  dpCtrlT                          ctrl,
  input  logic [NUM_THREADS-1:0]          inMask,
  input  logic [NUM_THREADS*ADDR_W-1:0]   inAddrs,
  output logic [NUM_LANES-1:0]            laneMask,
  output logic [NUM_LANES*ADDR_W-1:0]     laneAddrs,
  output logic                            lastBatch
);

  localparam int CNT_W  = $clog2(NUM_LANES + 1);
  localparam int LIDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam logic [CNT_W-1:0] LANES_C = CNT_W'(NUM_LANES);

  logic [NUM_THREADS-1:0] remMask;
  logic [NUM_THREADS-1:0] taken;
  logic [ADDR_W-1:0]      addrReg [NUM_THREADS];
  logic [ADDR_W-1:0]      laneAddr [NUM_LANES];
  logic [CNT_W-1:0]       fill;

  // remaining-thread mask: captured on accept, thinned on each handshake
  always_ff @(posedge clk) begin
    if (!rst_n)              remMask <= '0;
    else if (ctrl.capture)   remMask <= inMask;
    else if (ctrl.advance)   remMask <= remMask & ~taken;
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_addr
    always_ff @(posedge clk) begin
      if (!rst_n)            addrReg[t] <= '0;
      else if (ctrl.capture) addrReg[t] <= inAddrs[t*ADDR_W +: ADDR_W];
    end
  end

  // pick the lowest remaining threads, up to the lane count
  always_comb begin
    fill     = '0;
    taken    = '0;
    laneMask = '0;
    for (int k = 0; k < NUM_LANES; k++) laneAddr[k] = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (remMask[t] && (fill < LANES_C)) begin
        laneAddr[fill[LIDX_W-1:0]] = addrReg[t];
        laneMask[fill[LIDX_W-1:0]] = 1'b1;
        taken[t] = 1'b1;
        fill     = fill + CNT_W'(1);
      end
    end
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    assign laneAddrs[k*ADDR_W +: ADDR_W] = laneAddr[k];
  end

  assign lastBatch = ((remMask & ~taken) == '0);

endmodule

// File: rtl/mb_control.sv
module mb_control import mb_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   inValid,
  input  memOpE  inOp,
  input  logic   inReserve,
  input  logic   inMaskEmpty,
  input  logic   reqReady,
  input  logic   lastBatch,
  input  logic   tableFull,
  input  logic   tableEmpty,
  output logic   inReady,
  output logic   reqValid,
  output logic   reqWrite,
  output logic   allocate,
  output logic   doneValid,
  output dpCtrlT dpCtrl
);

  batchStateE state;
  logic       opWrite;
  logic       doneQ;
  logic       accept;
  logic       fire;
  logic       writeIn;

  assign writeIn  = (inOp == OP_STORE) || ((inOp == OP_ATOMIC) && !inReserve);
  assign inReady  = (state == ST_IDLE);
  assign accept   = inValid && inReady;
  assign reqValid = (state == ST_ISSUE) && (opWrite || !tableFull);
  assign fire     = reqValid && reqReady;
  assign allocate = fire && !opWrite;
  assign reqWrite = opWrite;
  assign doneValid = doneQ;

  assign dpCtrl.capture = accept && (inOp != OP_FENCE);
  assign dpCtrl.advance = fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      opWrite <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (inOp == OP_FENCE) begin
              state <= ST_FENCE;
            end else if (inMaskEmpty) begin
              doneQ <= 1'b1;
            end else begin
              state   <= ST_ISSUE;
              opWrite <= writeIn;
            end
          end
        end
        ST_ISSUE: begin
          if (fire && lastBatch) begin
            state <= ST_IDLE;
            doneQ <= opWrite;
          end
        end
        ST_FENCE: begin
          if (tableEmpty) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mem_batcher.sv
module mem_batcher import mb_pkg::*; #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_LANES   = 4,
  parameter int ADDR_W      = 32,
  parameter int READ_SLOTS  = 4,
  parameter int TAG_W       = (READ_SLOTS > 1) ? $clog2(READ_SLOTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inValid,
  output logic                          inReady,
  input  logic [1:0]                    inOp,
  input  logic                          inReserve,
  input  logic [NUM_THREADS-1:0]        inMask,
  input  logic [NUM_THREADS*ADDR_W-1:0] inAddrs,
  output logic                          reqValid,
  input  logic                          reqReady,
  output logic                          reqWrite,
  output logic [TAG_W-1:0]              reqTag,
  output logic                          reqEop,
  output logic [NUM_LANES-1:0]          reqLaneMask,
  output logic [NUM_LANES*ADDR_W-1:0]   reqAddrs,
  input  logic                          rspValid,
  input  logic [TAG_W-1:0]              rspTag,
  output logic                          doneValid
);

  dpCtrlT           dpCtrl;
  logic             lastBatch;
  logic             allocate;
  logic             tableFull;
  logic             tableEmpty;
  logic [TAG_W-1:0] allocTag;
  logic [READ_SLOTS-1:0] slotOcc;

  mb_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (inValid),
    .inOp       (memOpE'(inOp)),
    .inReserve  (inReserve),
    .inMaskEmpty(inMask == '0),
    .reqReady   (reqReady),
    .lastBatch  (lastBatch),
    .tableFull  (tableFull),
    .tableEmpty (tableEmpty),
    .inReady    (inReady),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .allocate   (allocate),
    .doneValid  (doneValid),
    .dpCtrl     (dpCtrl)
  );

  mb_datapath #(
    .NUM_THREADS(NUM_THREADS),
    .NUM_LANES  (NUM_LANES),
    .ADDR_W     (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (dpCtrl),
    .inMask   (inMask),
    .inAddrs  (inAddrs),
    .laneMask (reqLaneMask),
    .laneAddrs(reqAddrs),
    .lastBatch(lastBatch)
  );

  mb_slot_table #(
    .SLOTS(READ_SLOTS),
    .TAG_W(TAG_W)
  ) u_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .allocate    (allocate),
    .releaseValid(rspValid),
    .releaseTag  (rspTag),
    .allocTag    (allocTag),
    .full        (tableFull),
    .empty       (tableEmpty),
    .occupied    (slotOcc)
  );

  assign reqTag = reqWrite ? '0 : allocTag;
  assign reqEop = lastBatch;

endmodule

// File: rtl/mem_batcher_checker.sv
module mem_batcher_checker #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_LANES   = 4,
  parameter int ADDR_W      = 32,
  parameter int READ_SLOTS  = 4,
  parameter int TAG_W       = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          inValid,
  input logic                          inReady,
  input logic [1:0]                    inOp,
  input logic [NUM_THREADS-1:0]        inMask,
  input logic                          reqValid,
  input logic                          reqReady,
  input logic                          reqWrite,
  input logic [TAG_W-1:0]              reqTag,
  input logic                          reqEop,
  input logic [NUM_LANES-1:0]          reqLaneMask,
  input logic [NUM_LANES*ADDR_W-1:0]   reqAddrs,
  input logic                          rspValid,
  input logic [TAG_W-1:0]              rspTag,
  input logic                          doneValid,
  input logic                          tableFull,
  input logic [READ_SLOTS-1:0]         slotOcc
);

  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> reqLaneMask[0] && ((reqLaneMask & (reqLaneMask + NUM_LANES'(1))) == '0)); // R2

  AST_MID_BATCH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqEop |-> (&reqLaneMask)); // R3

  AST_EOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady && reqEop |=> !reqValid); // R4

  AST_WRITE_TAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqWrite |-> (reqTag == '0)); // R5

  AST_READ_TAG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqWrite |-> !slotOcc[reqTag]); // R5

  AST_RSP_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> slotOcc[rspTag]); // R5

  AST_NO_READ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqWrite |-> !tableFull); // R6

  AST_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady && reqEop && reqWrite |=> doneValid); // R8

  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && (inOp != 2'd3) && (inMask == '0) |=> doneValid && !reqValid); // R9

  AST_FENCE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && (inOp == 2'd3) |=> !inReady && !reqValid); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqReady |=> reqValid && $stable(reqAddrs) && $stable(reqLaneMask)
      && $stable(reqEop) && $stable(reqWrite)); // R11

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> !inReady); // R12

endmodule

bind mem_batcher mem_batcher_checker #(
  .NUM_THREADS(NUM_THREADS),
  .NUM_LANES  (NUM_LANES),
  .ADDR_W     (ADDR_W),
  .READ_SLOTS (READ_SLOTS),
  .TAG_W      (TAG_W)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .inValid    (inValid),
  .inReady    (inReady),
  .inOp       (inOp),
  .inMask     (inMask),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqWrite   (reqWrite),
  .reqTag     (reqTag),
  .reqEop     (reqEop),
  .reqLaneMask(reqLaneMask),
  .reqAddrs   (reqAddrs),
  .rspValid   (rspValid),
  .rspTag     (rspTag),
  .doneValid  (doneValid),
  .tableFull  (tableFull),
  .slotOcc    (slotOcc)
);

// File: tb/tb_mem_batcher.sv
module tb_mem_batcher;

  localparam int NT    = 8;
  localparam int NL    = 4;
  localparam int AW    = 32;
  localparam int SLOTS = 4;
  localparam int TW    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [1:0]    inOp = 2'd0;
  logic          inReserve = 1'b0;
  logic [NT-1:0] inMask = '0;
  logic [NT*AW-1:0] inAddrs = '0;
  logic          reqValid;
  logic          reqReady = 1'b1;
  logic          reqWrite;
  logic [TW-1:0] reqTag;
  logic          reqEop;
  logic [NL-1:0] reqLaneMask;
  logic [NL*AW-1:0] reqAddrs;
  logic          rspValid = 1'b0;
  logic [TW-1:0] rspTag = '0;
  logic          doneValid;

  int checks = 0;
  int fails  = 0;
  logic [SLOTS-1:0] modelOcc = '0;

  always #2 clk = ~clk;  // 4 ns period

  mem_batcher dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inOp(inOp), .inReserve(inReserve), .inMask(inMask), .inAddrs(inAddrs),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqTag(reqTag), .reqEop(reqEop), .reqLaneMask(reqLaneMask),
    .reqAddrs(reqAddrs), .rspValid(rspValid), .rspTag(rspTag),
    .doneValid(doneValid)
  );

  task automatic chk(input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic stepCycle();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  function automatic int lowestFree();
    for (int s = 0; s < SLOTS; s++) if (!modelOcc[s]) return s;
    return -1;
  endfunction

  // expected content of batch b for a given mask
  task automatic expBatch(input logic [NT-1:0] mask, input logic [31:0] base, input int b,
                          output logic [127:0] addrs, output logic [NL-1:0] lm,
                          output logic eop, output int nb);
    int idx = 0;
    addrs = '0;
    lm    = '0;
    for (int t = 0; t < NT; t++) begin
      if (mask[t]) begin
        int slot = idx - b * NL;
        if (slot >= 0 && slot < NL) begin
          addrs[slot*AW +: AW] = base + 32'(t * 4);
          lm[slot] = 1'b1;
        end
        idx++;
      end
    end
    nb  = (idx + NL - 1) / NL;
    eop = (b == nb - 1);
  endtask

  // offer an instruction; returns at the sample point after acceptance
  task automatic sendInstr(input logic [1:0] op, input logic res,
                           input logic [NT-1:0] mask, input logic [31:0] base);
    while (!inReady) stepCycle();
    inValid   = 1'b1;
    inOp      = op;
    inReserve = res;
    inMask    = mask;
    for (int t = 0; t < NT; t++) inAddrs[t*AW +: AW] = base + 32'(t * 4);
    @(posedge clk);
    #1;
    inValid = 1'b0;
    inAddrs = '0;
    inMask  = '0;
    @(negedge clk);
    #1;
  endtask

  task automatic releaseTag(input int t);
    rspValid = 1'b1;
    rspTag   = TW'(t);
    @(posedge clk);
    #1;
    rspValid = 1'b0;
    modelOcc[t] = 1'b0;
    @(negedge clk);
    #1;
  endtask

  // send an instruction and check every batch with reqReady held high
  task automatic runInstr(input logic [1:0] op, input logic res,
                          input logic [NT-1:0] mask, input logic [31:0] base);
    logic [127:0] ea;
    logic [NL-1:0] lm;
    logic eop;
    int nb;
    logic isWrite = (op == 2'd1) || (op == 2'd2 && !res);
    sendInstr(op, res, mask, base);
    expBatch(mask, base, 0, ea, lm, eop, nb);
    for (int b = 0; b < nb; b++) begin
      int et;
      expBatch(mask, base, b, ea, lm, eop, nb);
      et = isWrite ? 0 : lowestFree();
      chk("R3", "batch offered each cycle", 128'(reqValid), 128'(1));
      chk("R2", "lane mask", 128'(reqLaneMask), 128'(lm));
      chk("R2", "lane addresses", reqAddrs, ea);
      chk("R4", "end-of-packet", 128'(reqEop), 128'(eop));
      chk("R7", "write class", 128'(reqWrite), 128'(isWrite));
      chk("R5", "tag", 128'(reqTag), 128'(et));
      if (!isWrite) modelOcc[et] = 1'b1;
      stepCycle();
    end
    chk("R4", "idle after final batch", 128'(reqValid), 128'(0));
    chk("R8", "completion pulse", 128'(doneValid), 128'(isWrite));
  endtask

  task automatic testReset();
    chk("R1", "inReady in reset", 128'(inReady), 128'(1));
    chk("R1", "reqValid in reset", 128'(reqValid), 128'(0));
    rst_n = 1'b1;
    stepCycle();
    chk("R1", "inReady after reset", 128'(inReady), 128'(1));
    chk("R1", "reqValid after reset", 128'(reqValid), 128'(0));
    chk("R1", "doneValid after reset", 128'(doneValid), 128'(0));
  endtask

  task automatic testLoadAll();
    runInstr(2'd0, 1'b0, 8'hFF, 32'h1000);
    releaseTag(0);
    releaseTag(1);
  endtask

  task automatic testStores();
    runInstr(2'd1, 1'b0, 8'hA6, 32'h2000);
    runInstr(2'd1, 1'b0, 8'hFD, 32'h2100);
    stepCycle();
    chk("R8", "single completion pulse", 128'(doneValid), 128'(0));
  endtask

  task automatic testAtomics();
    runInstr(2'd2, 1'b0, 8'h0F, 32'h3000);
    runInstr(2'd2, 1'b1, 8'h30, 32'h3100);
    releaseTag(0);
  endtask

  task automatic testEmpty();
    sendInstr(2'd0, 1'b0, 8'h00, 32'h4000);
    chk("R9", "empty completes", 128'(doneValid), 128'(1));
    chk("R9", "empty issues nothing", 128'(reqValid), 128'(0));
    stepCycle();
    chk("R9", "pulse is one cycle", 128'(doneValid), 128'(0));
    chk("R9", "still no request", 128'(reqValid), 128'(0));
  endtask

  task automatic testBackpressure();
    logic [127:0] ea0, ea1;
    logic [NL-1:0] lm;
    logic eop;
    int nb;
    expBatch(8'h3F, 32'h5000, 0, ea0, lm, eop, nb);
    expBatch(8'h3F, 32'h5000, 1, ea1, lm, eop, nb);
    reqReady = 1'b0;
    sendInstr(2'd0, 1'b0, 8'h3F, 32'h5000);
    for (int i = 0; i < 3; i++) begin
      chk("R11", "held valid", 128'(reqValid), 128'(1));
      chk("R11", "held addresses", reqAddrs, ea0);
      chk("R12", "no accept while busy", 128'(inReady), 128'(0));
      stepCycle();
    end
    reqReady = 1'b1;
    modelOcc[0] = 1'b1;
    stepCycle();
    chk("R11", "second batch after one handshake", reqAddrs, ea1);
    chk("R2", "partial lane mask", 128'(reqLaneMask), 128'(4'b0011));
    chk("R5", "second tag", 128'(reqTag), 128'(1));
    chk("R4", "partial batch is final", 128'(reqEop), 128'(1));
    modelOcc[1] = 1'b1;
    stepCycle();
    chk("R4", "done issuing", 128'(reqValid), 128'(0));
    releaseTag(0);
    releaseTag(1);
  endtask

  task automatic testFull();
    runInstr(2'd0, 1'b0, 8'hFF, 32'h6000);
    runInstr(2'd0, 1'b0, 8'hFF, 32'h6100);
    sendInstr(2'd0, 1'b0, 8'h01, 32'h6200);
    for (int i = 0; i < 2; i++) begin
      chk("R6", "read held while full", 128'(reqValid), 128'(0));
      chk("R12", "busy while waiting", 128'(inReady), 128'(0));
      stepCycle();
    end
    releaseTag(2);
    chk("R6", "read offered after release", 128'(reqValid), 128'(1));
    chk("R6", "freed tag reused", 128'(reqTag), 128'(2));
    chk("R6", "position kept", reqAddrs, 128'(32'h6200));
    modelOcc[2] = 1'b1;
    stepCycle();
    chk("R6", "single batch sent", 128'(reqValid), 128'(0));
  endtask

  task automatic testFenceDrain();
    sendInstr(2'd3, 1'b0, 8'h00, 32'h0);
    chk("R10", "lock after fence", 128'(inReady), 128'(0));
    chk("R10", "no early completion", 128'(doneValid), 128'(0));
    releaseTag(0);
    releaseTag(1);
    releaseTag(3);
    chk("R10", "held while reads pending", 128'(doneValid), 128'(0));
    chk("R10", "still locked", 128'(inReady), 128'(0));
    releaseTag(2);
    chk("R10", "table just emptied", 128'(doneValid), 128'(0));
    chk("R10", "lock until next cycle", 128'(inReady), 128'(0));
    stepCycle();
    chk("R10", "fence completes", 128'(doneValid), 128'(1));
    chk("R10", "lock cleared", 128'(inReady), 128'(1));
    stepCycle();
    chk("R10", "pulse ends", 128'(doneValid), 128'(0));
  endtask

  task automatic testFenceIdle();
    sendInstr(2'd3, 1'b0, 8'hFF, 32'h0);
    chk("R10", "locked one cycle", 128'(inReady), 128'(0));
    chk("R10", "fence issues nothing", 128'(reqValid), 128'(0));
    stepCycle();
    chk("R10", "empty-table fence completes", 128'(doneValid), 128'(1));
    chk("R10", "accepting again", 128'(inReady), 128'(1));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    #1;
    stepCycle();
    testReset();
    testLoadAll();
    testStores();
    testAtomics();
    testEmpty();
    testBackpressure();
    testFull();
    testFenceDrain();
    testFenceIdle();
    stepCycle();
    summary();
    $finish;
  end

endmodule